// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit produces the effective memory address for one operand of a 16-bit processor whose operands are reached through registers. For each access it receives an addressing mode, a register number, an operand-size bit, a direction bit and the current register contents. It then returns the address, and where the mode updates the register, the new register value together with a write-back enable.

Three modes are supported: plain register-indirect, register-indirect with post-increment, and register-indirect plus a 16-bit unsigned displacement. The displacement comes in through a valid/ready handshake after the access has started. Register 15 serves as the stack pointer. In plain indirect mode it pushes on writes and pops on reads, always in whole words. Some combinations of mode, register and size are forbidden. These end at once with an illegal flag, and no address is used and no register is updated. Every arithmetic result wraps modulo 2^16.

Top module: `opnd_agu`

## Requirements
- R1: Mode 2'b01 (post-increment) on a register other than 15 gives `ea` equal to the register value and `wb_val` equal to the register value plus 1 when `byte_sel`=1 or plus 2 when `byte_sel`=0, modulo 2^16, with `wb_en`=1.
- R2: Mode 2'b00 (plain indirect) on a register other than 15 gives `ea` equal to the register value, with `wb_en`=0 and `illegal`=0, for either operand size.
- R3: Mode 2'b10 (displacement) raises `ofs_ready` in the cycle after `start` and keeps it high until `ofs_valid` is seen with it. In the following cycle `done`=1 and `ea` = (register value captured at start + `ofs_data`) mod 2^16. `wb_en` stays 0 in this mode, register 15 included.
- R4: Register 15 in mode 2'b00 with `wr`=1 and `byte_sel`=0 gives `ea` and `wb_val` both equal to the register value minus 2 mod 2^16, so 0x0000 gives 0xFFFE, with `wb_en`=1.
- R5: Register 15 in mode 2'b00 with `wr`=0 and `byte_sel`=0 gives `ea` equal to the register value and `wb_val` equal to the register value plus 2 mod 2^16, with `wb_en`=1.
- R6: Register 15 in mode 2'b00 with `byte_sel`=1 gives `illegal`=1, `wb_en`=0 and `ea`=0.
- R7: Register 15 in mode 2'b01, and mode 2'b11 for any register, give `illegal`=1, `wb_en`=0 and `ea`=0.
- R8: For modes other than 2'b10, `done` is high exactly in the cycle after `start`. `wb_en` and `illegal` are only ever high together with `done`.
- R9: While `ofs_ready` is high, `start` is ignored. The pending access finishes with its own captured register value.
- R10: After reset, `done`, `wb_en`, `illegal` and `ofs_ready` are 0 and `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one access |
| mode | input | 2 | 00 indirect, 01 post-increment, 10 displacement, 11 reserved |
| reg_sel | input | 4 | Address register number |
| byte_sel | input | 1 | 1 byte operand, 0 word operand |
| wr | input | 1 | 1 write access, 0 read access |
| reg_val | input | 16 | Current register contents |
| ofs_valid | input | 1 | Displacement word available |
| ofs_data | input | 16 | Unsigned displacement word |
| ofs_ready | output | 1 | Unit is waiting for the displacement |
| ea | output | 16 | Effective address |
| wb_val | output | 16 | New register value |
| wb_en | output | 1 | Write `wb_val` back to the register |
| illegal | output | 1 | Forbidden combination, access dropped |
| done | output | 1 | Access finished this cycle |

## Verification
The assertions take for granted that `mode`, `reg_sel`, `byte_sel`, `wr` and `reg_val` are valid whenever `start` is high. They also assume that `ofs_data` is meaningful only while `ofs_valid` is high. The stimulus changes inputs only on the falling edge and holds `start` high for a single cycle. It raises `ofs_valid` only once `ofs_ready` has been seen, except in one deliberate test. In that test `start` is pulsed during the wait, to show that it is ignored.

// File: rtl/opnd_agu.sv
module opnd_agu #(
  parameter int AW     = 16,
  parameter int RW     = 4,
  parameter int SP_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [RW-1:0] reg_sel,
  input  logic          byte_sel,
  input  logic          wr,
  input  logic [AW-1:0] reg_val,
  input  logic          ofs_valid,
  input  logic [AW-1:0] ofs_data,
  output logic          ofs_ready,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb_val,
  output logic          wb_en,
  output logic          illegal,
  output logic          done
);
  localparam logic [1:0] M_IND = 2'b00;
  localparam logic [1:0] M_INC = 2'b01;
  localparam logic [1:0] M_OFS = 2'b10;
  localparam logic [RW-1:0] SP = RW'(SP_IDX);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic          waiting;
  logic [AW-1:0] base_q;

  wire          is_sp = (reg_sel == SP);
  wire [AW-1:0] step  = byte_sel ? AW'(1) : TWO;
  wire          bad   = (mode == 2'b11) || (is_sp && mode == M_INC) ||
                        (is_sp && mode == M_IND && byte_sel);

  assign ofs_ready = waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      base_q  <= '0;
      ea      <= '0;
      wb_val  <= '0;
      wb_en   <= 1'b0;
      illegal <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      wb_en   <= 1'b0;
      illegal <= 1'b0;
      if (waiting) begin
        if (ofs_valid) begin
          ea      <= base_q + ofs_data;
          done    <= 1'b1;
          waiting <= 1'b0;
        end
      end else if (start) begin
        if (bad) begin
          ea      <= '0;
          illegal <= 1'b1;
          done    <= 1'b1;
        end else if (mode == M_OFS) begin
          base_q  <= reg_val;
          waiting <= 1'b1;
        end else if (is_sp) begin
          ea     <= wr ? reg_val - TWO : reg_val;
          wb_val <= wr ? reg_val - TWO : reg_val + TWO;
          wb_en  <= 1'b1;
          done   <= 1'b1;
        end else begin
          ea     <= reg_val;
          wb_val <= reg_val + step;
          wb_en  <= (mode == M_INC);
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/opnd_agu_chk.sv
module opnd_agu_chk #(
  parameter int AW     = 16,
  parameter int RW     = 4,
  parameter int SP_IDX = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic [RW-1:0] reg_sel,
  input logic          byte_sel,
  input logic          wr,
  input logic [AW-1:0] reg_val,
  input logic          ofs_valid,
  input logic [AW-1:0] ofs_data,
  input logic          ofs_ready,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] wb_val,
  input logic          wb_en,
  input logic          illegal,
  input logic          done
);
  wire is_sp = (reg_sel == RW'(SP_IDX));

  assert_wben_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  assert_illegal_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wb_en));
  assert_quick_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ofs_ready && mode != 2'b10) |=> done);
  assert_ofs_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ofs_ready && mode == 2'b10) |=> (ofs_ready && !done));
  assert_ofs_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_ready && ofs_valid) |=> (done && !wb_en && !illegal && !ofs_ready));
  assert_ofs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_ready && !ofs_valid) |=> (ofs_ready && !done));
  assert_plain_ea_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ofs_ready && mode == 2'b00 && !is_sp) |=>
      (!wb_en && !illegal && ea == $past(reg_val)));
  assert_sp_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ofs_ready && mode == 2'b00 && is_sp && byte_sel) |=> illegal);
  assert_sp_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ofs_ready && mode == 2'b01 && is_sp) |=> illegal);
  assert_push_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ofs_ready && mode == 2'b00 && is_sp && !byte_sel && wr) |=>
      (wb_en && ea == wb_val));
endmodule

bind opnd_agu opnd_agu_chk #(.AW(AW), .RW(RW), .SP_IDX(SP_IDX)) u_chk (.*);

// File: tb/opnd_agu_tb.sv
module opnd_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [3:0]  reg_sel = '0;
  logic        byte_sel = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] reg_val = '0;
  logic        ofs_valid = 1'b0;
  logic [15:0] ofs_data = '0;
  logic        ofs_ready;
  logic [15:0] ea, wb_val;
  logic        wb_en, illegal, done;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  opnd_agu u_dut (.*);

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  m;
    logic [3:0]  r;
    logic        b;
    logic        w;
    logic [15:0] v;
    logic [15:0] x_ea;
    logic [15:0] x_wb;
    logic        x_en;
    logic        x_ill;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 2'd0, 4'd3,  1'b0, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b0}, // R2
    '{8'd2, 2'd0, 4'd0,  1'b1, 1'b1, 16'h00FF, 16'h00FF, 16'h0000, 1'b0, 1'b0}, // R2
    '{8'd1, 2'd1, 4'd5,  1'b1, 1'b0, 16'h1000, 16'h1000, 16'h1001, 1'b1, 1'b0}, // R1
    '{8'd1, 2'd1, 4'd7,  1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1, 1'b0}, // R1
    '{8'd1, 2'd1, 4'd14, 1'b0, 1'b0, 16'hFFFE, 16'hFFFE, 16'h0000, 1'b1, 1'b0}, // R1
    '{8'd4, 2'd0, 4'd15, 1'b0, 1'b1, 16'h0400, 16'h03FE, 16'h03FE, 1'b1, 1'b0}, // R4
    '{8'd4, 2'd0, 4'd15, 1'b0, 1'b1, 16'h0000, 16'hFFFE, 16'hFFFE, 1'b1, 1'b0}, // R4
    '{8'd5, 2'd0, 4'd15, 1'b0, 1'b0, 16'h0400, 16'h0400, 16'h0402, 1'b1, 1'b0}, // R5
    '{8'd5, 2'd0, 4'd15, 1'b0, 1'b0, 16'hFFFE, 16'hFFFE, 16'h0000, 1'b1, 1'b0}, // R5
    '{8'd6, 2'd0, 4'd15, 1'b1, 1'b0, 16'h0400, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R6
    '{8'd6, 2'd0, 4'd15, 1'b1, 1'b1, 16'h0400, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R6
    '{8'd7, 2'd1, 4'd15, 1'b0, 1'b0, 16'h2000, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R7
    '{8'd7, 2'd3, 4'd2,  1'b0, 1'b0, 16'h2000, 16'h0000, 16'h0000, 1'b0, 1'b1}  // R7
  };

  task automatic chk(input int rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [3:0] r, input logic b,
                       input logic w, input logic [15:0] v);
    @(negedge clk);
    mode = m; reg_sel = r; byte_sel = b; wr = w; reg_val = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic give_ofs(input logic [15:0] d);
    ofs_valid = 1'b1; ofs_data = d;
    @(negedge clk);
    ofs_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(10, "done", 16'(done), 16'h0);
    chk(10, "wb_en", 16'(wb_en), 16'h0);
    chk(10, "illegal", 16'(illegal), 16'h0);
    chk(10, "ofs_ready", 16'(ofs_ready), 16'h0);
    chk(10, "ea", ea, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].m, VECS[i].r, VECS[i].b, VECS[i].w, VECS[i].v);
      chk(8, "done", 16'(done), 16'h1);
      chk(int'(VECS[i].rq), "ea", ea, VECS[i].x_ea);
      chk(int'(VECS[i].rq), "wb_en", 16'(wb_en), 16'(VECS[i].x_en));
      chk(int'(VECS[i].rq), "illegal", 16'(illegal), 16'(VECS[i].x_ill));
      if (VECS[i].x_en) chk(int'(VECS[i].rq), "wb_val", wb_val, VECS[i].x_wb);
      @(negedge clk);
      chk(8, "done drop", 16'(done), 16'h0);
      chk(8, "wb_en drop", 16'(wb_en), 16'h0);
    end

    // R3 displacement with delayed handshake and wrap
    issue(2'd2, 4'd4, 1'b0, 1'b0, 16'hFFF0);
    chk(3, "ready", 16'(ofs_ready), 16'h1);
    chk(3, "no done", 16'(done), 16'h0);
    @(negedge clk);
    chk(3, "still ready", 16'(ofs_ready), 16'h1);
    give_ofs(16'h0020);
    chk(3, "done", 16'(done), 16'h1);
    chk(3, "ea wrap", ea, 16'h0010);
    chk(3, "wb_en", 16'(wb_en), 16'h0);
    chk(3, "ready low", 16'(ofs_ready), 16'h0);

    // R3 stack pointer in displacement mode, byte write, no update
    issue(2'd2, 4'd15, 1'b1, 1'b1, 16'h0100);
    give_ofs(16'h0023);
    chk(3, "sp ea", ea, 16'h0123);
    chk(3, "sp wb_en", 16'(wb_en), 16'h0);
    chk(3, "sp illegal", 16'(illegal), 16'h0);

    // R9 start ignored while waiting
    issue(2'd2, 4'd1, 1'b0, 1'b0, 16'h0500);
    issue(2'd1, 4'd2, 1'b0, 1'b0, 16'h7777);
    chk(9, "ready kept", 16'(ofs_ready), 16'h1);
    chk(9, "no done", 16'(done), 16'h0);
    chk(9, "no wb", 16'(wb_en), 16'h0);
    give_ofs(16'h0005);
    chk(9, "ea from first", ea, 16'h0505);
    chk(9, "wb_en", 16'(wb_en), 16'h0);

    // R10 reset in the middle of a wait
    issue(2'd2, 4'd1, 1'b0, 1'b0, 16'h0001);
    rst_n = 1'b0;
    @(negedge clk);
    chk(10, "ready after reset", 16'(ofs_ready), 16'h0);
    chk(10, "ea after reset", ea, 16'h0);
    rst_n = 1'b1;

    // R8 back-to-back accesses
    issue(2'd0, 4'd6, 1'b0, 1'b0, 16'hABCD);
    chk(8, "b2b first", ea, 16'hABCD);
    issue(2'd1, 4'd6, 1'b1, 1'b0, 16'hABCD);
    chk(8, "b2b done", 16'(done), 16'h1);
    chk(1, "b2b wb", wb_val, 16'hABCE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule